// File: doc/BRIEF.md
# Periodic tick timer

A 24-bit down-counter that produces a steady heartbeat for system software. It is reached through four word-aligned 32-bit registers: control/status, reload value, current value and a read-only calibration constant. Each time the count passes through zero, the timer sets a sticky flag, reloads itself and, when interrupts are enabled, emits a one-cycle interrupt pulse. The count advances either on every core clock or on a slower reference strobe, chosen by a control bit.

Software programs a reload value, clears the counter by writing the current-value register and sets the enable bit. It then takes either the interrupt or polls the sticky flag, which clears when the control/status register is read. A reload value of zero makes the timer fire once and then switch itself off.

Top module: `tick_timer`

## Requirements
- R1: Register offsets are 0x0 control/status, 0x4 reload, 0x8 current value and 0xC calibration. Every other address reads 0, and writes to it change no state.
- R2: Control bits are enable at bit 0, interrupt enable at bit 1, clock source at bit 2 (1 = every core clock, 0 = reference strobe) and the sticky flag at bit 16. Only bits [2:0] take write data. Every other bit reads 0 except the flag.
- R3: A read of control/status returns the flag as it stands and then clears it. A wrap in the same cycle leaves the flag set.
- R4: A write of any data to the current-value register loads the counter from the reload register and clears the flag.
- R5: On a counting tick with the counter at zero, the timer wraps. It sets the flag and reloads, so the period is reload+1 ticks. With interrupt enable set, the irq output is high for exactly one cycle, in the cycle after the wrap edge.
- R6: A wrap while the reload value is zero clears the enable bit, and counting stops.
- R7: When enable goes from 0 to 1 with the counter at zero, the counter loads the reload value. With a nonzero held count, counting resumes from that count.
- R8: While enable is 0, the current-value register reads 0.
- R9: The calibration register reads the constant 10000.
- R10: A control write that flips the clock-source bit and leaves enable unchanged reloads the counter.
- R11: Reset clears control, flag, reload and counter, and holds irq low.
- R12: The reload and current-value registers are 24 bits wide, and bits [31:24] read 0.
- R13: The counter steps once per core clock when the clock-source bit is 1, and once per reference strobe when it is 0. A write to control or current value in the same cycle takes precedence, and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read of control/status has a side effect |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, 0 when rd_en is low |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
The bench sweeps reload values 1 through 6 on the core clock. It checks the counter value and the interrupt every cycle over three periods, so an off-by-one period or a stretched pulse would show up at once. A zero reload must fire exactly once and then drop the enable bit; a design that reloaded instead would keep pulsing. Strobe counting, reload on a clock-source flip, resume versus load on re-enable, and the read-to-clear flag are each checked at the cycle where a wrong design would show a stale count or a flag that stays set. A full sweep of all 256 addresses after reset checks the register decode and the calibration constant.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned OFS_CTRL = 'h0;
  localparam int unsigned OFS_RLD  = 'h4;
  localparam int unsigned OFS_CUR  = 'h8;
  localparam int unsigned OFS_CAL  = 'hC;

  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_IE   = 1;
  localparam int unsigned BIT_SRC  = 2;
  localparam int unsigned BIT_FLAG = 16;

  localparam int unsigned CAL_VALUE = 10000;

  typedef struct packed {
    logic src;
    logic ie;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cur,
  output logic             wrap
);
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c,
                                                 input logic [CNT_W-1:0] r);
    return (c == '0) ? r : c - 1'b1;
  endfunction

  assign wrap = tick && !load && (cur == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur <= '0;
    else if (load) cur <= reload_val;
    else if (tick) cur <= step_down(cur, reload_val);
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cur)); // R13
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur == $past(reload_val)); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cur != '0) |=> cur == $past(cur) - 1'b1); // R13
endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wrap,
  input  logic [CNT_W-1:0]  cur_val,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              cnt_load,
  output logic              bus_hold,
  output logic              flag,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  logic  sel_ctrl, sel_rld, sel_cur, sel_cal;
  logic  wr_ctrl, wr_rld, wr_cur, rd_ctrl;
  logic  en_rise, src_chg;
  ctrl_t new_ctrl;

  function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c, input logic f);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BIT_EN]   = c.en;
    w[BIT_IE]   = c.ie;
    w[BIT_SRC]  = c.src;
    w[BIT_FLAG] = f;
    return w;
  endfunction

  assign sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign sel_rld  = (addr == ADDR_W'(OFS_RLD));
  assign sel_cur  = (addr == ADDR_W'(OFS_CUR));
  assign sel_cal  = (addr == ADDR_W'(OFS_CAL));

  assign wr_ctrl = wr_en && sel_ctrl;
  assign wr_rld  = wr_en && sel_rld;
  assign wr_cur  = wr_en && sel_cur;
  assign rd_ctrl = rd_en && sel_ctrl;

  assign new_ctrl = '{src: wdata[BIT_SRC], ie: wdata[BIT_IE], en: wdata[BIT_EN]};
  assign en_rise  = wr_ctrl && new_ctrl.en && !ctrl.en;
  assign src_chg  = wr_ctrl && (new_ctrl.en == ctrl.en) && (new_ctrl.src != ctrl.src);
  assign cnt_load = wr_cur || src_chg || (en_rise && cur_val == '0);
  assign bus_hold = wr_ctrl || wr_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      reload <= '0;
      flag   <= 1'b0;
    end else begin
      if (wr_ctrl)                       ctrl    <= new_ctrl;
      else if (wrap && reload == '0)     ctrl.en <= 1'b0;
      if (wr_rld)                        reload  <= wdata[CNT_W-1:0];
      if (wrap)                          flag    <= 1'b1;
      else if (rd_ctrl || wr_cur)        flag    <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (sel_ctrl)     rdata = ctrl_word(ctrl, flag);
      else if (sel_rld) rdata = {{PAD_W{1'b0}}, reload};
      else if (sel_cur) rdata = ctrl.en ? {{PAD_W{1'b0}}, cur_val} : '0;
      else if (sel_cal) rdata = DATA_W'(CAL_VALUE);
    end
  end

  AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag); // R5
  AST_ZERO_RELOAD_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && reload == '0) |=> !ctrl.en); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !wrap) |=> !flag); // R3
  AST_CUR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cur |=> !flag); // R4
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, cur;
  logic             cnt_load, bus_hold, flag, wrap, tick;

  assign tick = ctrl.en && (ctrl.src || ref_tick) && !bus_hold;

  tt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .wrap(wrap), .cur_val(cur), .ctrl(ctrl), .reload(reload),
    .cnt_load(cnt_load), .bus_hold(bus_hold), .flag(flag), .rdata(rdata)
  );

  tt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
    .reload_val(reload), .cur(cur), .wrap(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= wrap && ctrl.ie;
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R5
  AST_IRQ_FROM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wrap)); // R5
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == ADDR_W'(OFS_RLD) || addr == ADDR_W'(OFS_CUR)))
      |-> rdata[DATA_W-1:CNT_W] == '0); // R12
  AST_DISABLED_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && !cnt_load) |=> $stable(cur)); // R8
endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  localparam int CLK_P = 10;
  localparam logic [7:0] A_CTRL = 8'h0, A_RLD = 8'h4, A_CUR = 8'h8, A_CAL = 8'hC;

  logic        clk = 0, rst_n = 0, ref_tick = 0, wr_en = 0, rd_en = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  tick_timer dut (.clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
                  .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P*200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    logic [31:0] v;
    int strobes;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 irq after reset", {31'b0, irq}, 32'd0);

    // R1 R9 R11: full address sweep after reset
    for (int a = 0; a < 256; a++) begin
      bus_rd(8'(a), v);
      chk("R1 R9 R11 address sweep", v, (a == 'hC) ? 32'd10000 : 32'd0);
    end

    // R1: unmapped writes ignored
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_wr(8'h03, 32'hFFFF_FFFF);
    bus_rd(A_CTRL, v); chk("R1 unmapped write ctrl", v, 32'd0);
    bus_rd(A_RLD, v);  chk("R1 unmapped write reload", v, 32'd0);

    // R2: writable bits
    bus_wr(A_CTRL, 32'hFFFF_FFF8);
    bus_rd(A_CTRL, v); chk("R2 only low bits writable", v, 32'd0);
    bus_wr(A_CTRL, 32'h6);
    bus_rd(A_CTRL, v); chk("R2 ie src stored", v, 32'h6);

    // R12: reload width
    bus_wr(A_RLD, 32'hFFFF_FFFF);
    bus_rd(A_RLD, v); chk("R12 reload upper bits", v, 32'h00FF_FFFF);

    // R5 R13: period sweep on core clock
    for (int r = 1; r <= 6; r++) begin
      bus_wr(A_RLD, 32'(r));
      bus_wr(A_CUR, 32'h0);
      bus_wr(A_CTRL, 32'h7);
      rd_en = 1; addr = A_CUR;
      for (int k = 1; k <= 3 * (r + 1); k++) begin
        @(negedge clk); #1;
        chk("R5 R13 count value", rdata, 32'(r - (k % (r + 1))));
        chk("R5 irq pulse", {31'b0, irq}, {31'b0, (k % (r + 1)) == 0});
      end
      @(negedge clk);
      rd_en = 0;
      bus_wr(A_CTRL, 32'h6);
      bus_rd(A_CTRL, v);
    end

    // R6: zero reload is one-shot
    bus_wr(A_RLD, 32'h0);
    bus_wr(A_CUR, 32'h0);
    bus_wr(A_CTRL, 32'h7);
    #1 chk("R6 irq before wrap", {31'b0, irq}, 32'd0);
    @(negedge clk); #1 chk("R6 irq on wrap", {31'b0, irq}, 32'd1);
    @(negedge clk); #1 chk("R6 irq single", {31'b0, irq}, 32'd0);
    bus_rd(A_CTRL, v); chk("R6 R3 enable dropped flag set", v, 32'h0001_0006);
    bus_rd(A_CTRL, v); chk("R3 flag cleared by read", v, 32'h6);

    // R7: enable from zero count loads reload
    bus_wr(A_RLD, 32'h4);
    bus_wr(A_CTRL, 32'h5);
    bus_rd(A_CUR, v); chk("R7 load on enable", v, 32'h4);
    bus_wr(A_CTRL, 32'h4);

    // R13: reference strobe counting
    bus_wr(A_RLD, 32'h3);
    bus_wr(A_CUR, 32'h0);
    bus_wr(A_CTRL, 32'h1);
    strobes = 0;
    rd_en = 1; addr = A_CUR;
    for (int j = 0; j < 12; j++) begin
      ref_tick = (j % 2 == 0);
      @(negedge clk);
      if (ref_tick) strobes++;
      ref_tick = 0;
      #1 chk("R13 strobe count", rdata, 32'(3 - (strobes % 4)));
    end
    rd_en = 0;

    // R10: source flip reloads (count is 1 here)
    bus_wr(A_CTRL, 32'h5);
    bus_rd(A_CUR, v); chk("R10 source change reload", v, 32'h3);
    bus_rd(A_CUR, v); chk("R10 counts after flip", v, 32'h2);
    repeat (4) @(negedge clk);

    // R4: current write reloads and clears flag
    bus_wr(A_CUR, 32'hABCD_EF01);
    bus_rd(A_CUR, v);  chk("R4 cur write reload", v, 32'h3);
    bus_rd(A_CTRL, v); chk("R4 cur write clears flag", v, 32'h5);
    repeat (3) @(negedge clk);
    bus_rd(A_CTRL, v); chk("R3 flag visible", v, 32'h0001_0005);
    bus_rd(A_CTRL, v); chk("R3 flag read-cleared", v, 32'h5);

    // R7 R8: disable holds, read zero, resume
    bus_wr(A_CTRL, 32'h4);
    bus_wr(A_RLD, 32'h9);
    bus_wr(A_CUR, 32'h0);
    bus_wr(A_CTRL, 32'h5);
    bus_rd(A_CUR, v); chk("R7 resume held 9", v, 32'h9);
    bus_wr(A_CTRL, 32'h4);
    bus_rd(A_CUR, v); chk("R8 disabled reads zero", v, 32'h0);
    repeat (3) @(negedge clk);
    bus_wr(A_CTRL, 32'h5);
    bus_rd(A_CUR, v); chk("R7 resume from held count", v, 32'h8);
    bus_rd(A_CUR, v); chk("R12 R13 continues", v, 32'h7);

    report();
  end
endmodule